// File: doc/BRIEF.md
# Dual Gated Reference Clock Generator

This block derives two reference clocks from a choice of three PLL sources. Each PLL is reduced to a simple behavioural model. Depending on its 32-bit control word, a PLL model does one of three things: it forwards the primary reference clock, it holds its output off, or it passes through a supplied fast clock. The fast clock stands in for the multiplied PLL output. The multiplier field of each control word is not synthesised. It is reported on a status output.

A single 32-bit clock control word drives the rest of the path:
- a 2-bit field picks one of the three PLL outputs as the source;
- a 6-bit field sets an integer divisor for that source;
- two enable bits gate the two outputs separately.

Both outputs share the same source and divider, so they are always identical in frequency and phase. They differ only in whether each is enabled.

The divider runs on the selected source clock. Whenever the source select or the divisor changes, the divider counter restarts, so the new waveform begins at the next source edge. The block has no data stream. Every pin is a plain control, status or clock pin.

Top module: `dual_refclk_gen`

## Requirements
- R1: When bit 4 (force-bypass) of a PLL control word is set, that PLL's output is the primary reference clock, whatever bits 0 and 1 hold.
- R2: When bit 4 is clear and bit 0 (reset) or bit 1 (power-down) is set, that PLL's output is held low.
- R3: When bits 0, 1 and 4 are all clear, the PLL output is that PLL's fast clock input. Bits 18:12 of each PLL word appear on `pll_mult_o`: the I/O PLL at [6:0], the CPU PLL at [13:7], the memory PLL at [20:14].
- R4: Clock control bits 5:4 select the source: 0 or 1 selects the I/O PLL, 2 selects the CPU PLL, 3 selects the memory PLL.
- R5: Clock control bits 13:8 hold the divisor N. An output period is N source periods. N = 0 and N = 1 both pass the source through undivided.
- R6: For N >= 2 the high phase lasts floor(N/2) source periods and the low phase lasts the rest. Even divisors therefore give 50% duty. With odd divisors the high phase is one source period shorter than the low phase.
- R7: Clock control bit 0 enables `ref_clk0_o` and bit 1 enables `ref_clk1_o`. While its enable bit is clear, an output stays low.
- R8: While `rst_ni` is low, both outputs are low and the divider is cleared. After release, the outputs follow the current control words.
- R9: A change of source select or divisor restarts the divider. On the first source rising edge that sees the new setting, the count returns to zero and the high phase begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Primary reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_fast_clk_i | input | 1 | Multiplied clock of the I/O PLL |
| cpu_fast_clk_i | input | 1 | Multiplied clock of the CPU PLL |
| mem_fast_clk_i | input | 1 | Multiplied clock of the memory PLL |
| io_pll_ctrl_i | input | 32 | I/O PLL control word |
| cpu_pll_ctrl_i | input | 32 | CPU PLL control word |
| mem_pll_ctrl_i | input | 32 | Memory PLL control word |
| clk_ctrl_i | input | 32 | Source select, divisor and enables |
| ref_clk0_o | output | 1 | Gated divided reference clock 0 |
| ref_clk1_o | output | 1 | Gated divided reference clock 1 |
| pll_mult_o | output | 21 | Multiplier fields of the three PLL words |

## Verification
Some results settle combinationally within the same delta cycle as the input change:
- the PLL mode decisions,
- the enable gating,
- the undivided path,
- the multiplier status.

A divided output changes only at source rising edges. After a setting change, the first new high phase begins on the first source edge that sees the change, which is at most one source period later. Each scenario task therefore waits a settle time of several output periods before it measures. It then timestamps a rising edge, the following falling edge and the next rising edge, and compares the high time and the period against exact multiples of the source period. Rates and absent outputs are checked by counting rising edges over an 840 ns window. That window is a whole multiple of every source period used. The restart check is the exception: it times the gap from the setting change to the next rising edge and requires it to be no longer than one source period.

// File: rtl/refclk_pkg.sv
`timescale 1ns/1ps
package refclk_pkg;
  localparam int CTRL_W    = 32;
  localparam int SEL_W     = 2;
  localparam int DIV_W     = 6;
  localparam int MULT_W    = 7;
  localparam int NUM_PLL   = 3;
  localparam int NUM_OUT   = 2;
  localparam int CFG_W     = SEL_W + DIV_W;

  localparam int PLL_RST_BIT  = 0;
  localparam int PLL_PD_BIT   = 1;
  localparam int PLL_BYP_BIT  = 4;
  localparam int PLL_MULT_LSB = 12;
  localparam int SEL_LSB      = 4;
  localparam int DIV_LSB      = 8;

  typedef enum logic [1:0] {
    SRC_IO  = 2'd0,
    SRC_CPU = 2'd1,
    SRC_MEM = 2'd2
  } src_idx_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
  } div_cfg_t;

  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  function automatic src_idx_e sel_to_src(input logic [SEL_W-1:0] s);
    if (!s[1]) return SRC_IO;
    return s[0] ? SRC_MEM : SRC_CPU;
  endfunction
endpackage

// File: rtl/refclk_pll_model.sv
`timescale 1ns/1ps
module refclk_pll_model
  import refclk_pkg::*;
(
  input  logic              ref_clk_i,
  input  logic              fast_clk_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              pll_clk_o,
  output logic [MULT_W-1:0] mult_o
);
  logic bypass, held_off;

  assign bypass   = ctrl_i[PLL_BYP_BIT];
  assign held_off = ctrl_i[PLL_RST_BIT] | ctrl_i[PLL_PD_BIT];
  assign mult_o   = ctrl_i[PLL_MULT_LSB +: MULT_W];

  always_comb begin
    if (bypass)        pll_clk_o = ref_clk_i;
    else if (held_off) pll_clk_o = 1'b0;
    else               pll_clk_o = fast_clk_i;
  end

  wire unused_ctrl = ^{ctrl_i[CTRL_W-1:PLL_MULT_LSB+MULT_W],
                       ctrl_i[PLL_MULT_LSB-1:PLL_BYP_BIT+1],
                       ctrl_i[PLL_BYP_BIT-1:PLL_PD_BIT+1]};
endmodule

// File: rtl/refclk_src_mux.sv
`timescale 1ns/1ps
module refclk_src_mux
  import refclk_pkg::*;
(
  input  logic [NUM_PLL-1:0] pll_clk_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               src_clk_o
);
  src_idx_e idx;

  assign idx = sel_to_src(sel_i);

  always_comb begin
    unique case (idx)
      SRC_CPU: src_clk_o = pll_clk_i[SRC_CPU];
      SRC_MEM: src_clk_o = pll_clk_i[SRC_MEM];
      default: src_clk_o = pll_clk_i[SRC_IO];
    endcase
  end
endmodule

// File: rtl/refclk_divider.sv
`timescale 1ns/1ps
module refclk_divider
  import refclk_pkg::*;
(
  input  logic             src_clk_i,
  input  logic             rst_ni,
  input  div_cfg_t         cfg_i,
  output logic             base_clk_o,
  output div_cfg_t         cfg_q_o,
  output logic [DIV_W-1:0] cnt_o,
  output logic             phase_o
);
  div_cfg_t         cfg_q;
  logic [DIV_W-1:0] cnt_q, cnt_nxt, n_q, hi_q, hi_new;
  logic             phase_q, live_undivided;

  assign n_q    = eff_div(cfg_q.div);
  assign hi_q   = n_q >> 1;
  assign hi_new = eff_div(cfg_i.div) >> 1;
  assign cnt_nxt = (cnt_q >= n_q - DIV_W'(1)) ? '0 : cnt_q + DIV_W'(1);

  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (cfg_i != cfg_q) begin
      cfg_q   <= cfg_i;
      cnt_q   <= '0;
      phase_q <= (hi_new != '0);
    end else begin
      cnt_q   <= cnt_nxt;
      phase_q <= (cnt_nxt < hi_q);
    end
  end

  assign live_undivided = (eff_div(cfg_i.div) == DIV_W'(1));
  assign base_clk_o     = live_undivided ? src_clk_i : phase_q;
  assign cfg_q_o        = cfg_q;
  assign cnt_o          = cnt_q;
  assign phase_o        = phase_q;
endmodule

// File: rtl/dual_refclk_gen.sv
`timescale 1ns/1ps
module dual_refclk_gen
  import refclk_pkg::*;
(
  input  logic                      ref_clk_i,
  input  logic                      rst_ni,
  input  logic                      io_fast_clk_i,
  input  logic                      cpu_fast_clk_i,
  input  logic                      mem_fast_clk_i,
  input  logic [31:0]               io_pll_ctrl_i,
  input  logic [31:0]               cpu_pll_ctrl_i,
  input  logic [31:0]               mem_pll_ctrl_i,
  input  logic [31:0]               clk_ctrl_i,
  output logic                      ref_clk0_o,
  output logic                      ref_clk1_o,
  output logic [NUM_PLL*MULT_W-1:0] pll_mult_o
);
  logic [NUM_PLL-1:0]             fast_clk, pll_clk;
  logic [NUM_PLL-1:0][CTRL_W-1:0] pll_ctrl;
  logic [NUM_OUT-1:0]             out_en, out_clk;
  logic                           src_clk, base_clk, div_phase;
  logic [DIV_W-1:0]               div_cnt;
  div_cfg_t                       live_cfg, cfg_q;

  assign fast_clk = {mem_fast_clk_i, cpu_fast_clk_i, io_fast_clk_i};
  assign pll_ctrl = {mem_pll_ctrl_i, cpu_pll_ctrl_i, io_pll_ctrl_i};

  for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll
    refclk_pll_model u_pll (
      .ref_clk_i  (ref_clk_i),
      .fast_clk_i (fast_clk[p]),
      .ctrl_i     (pll_ctrl[p]),
      .pll_clk_o  (pll_clk[p]),
      .mult_o     (pll_mult_o[p*MULT_W +: MULT_W])
    );
  end

  assign live_cfg.sel = clk_ctrl_i[SEL_LSB +: SEL_W];
  assign live_cfg.div = clk_ctrl_i[DIV_LSB +: DIV_W];
  assign out_en       = clk_ctrl_i[NUM_OUT-1:0];

  refclk_src_mux u_mux (
    .pll_clk_i (pll_clk),
    .sel_i     (live_cfg.sel),
    .src_clk_o (src_clk)
  );

  refclk_divider u_div (
    .src_clk_i  (src_clk),
    .rst_ni     (rst_ni),
    .cfg_i      (live_cfg),
    .base_clk_o (base_clk),
    .cfg_q_o    (cfg_q),
    .cnt_o      (div_cnt),
    .phase_o    (div_phase)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_gate
    assign out_clk[g] = rst_ni & out_en[g] & base_clk;
  end

  assign ref_clk0_o = out_clk[0];
  assign ref_clk1_o = out_clk[1];

  wire unused_ctrl = ^{clk_ctrl_i[CTRL_W-1:DIV_LSB+DIV_W],
                       clk_ctrl_i[DIV_LSB-1:SEL_LSB+SEL_W],
                       clk_ctrl_i[SEL_LSB-1:NUM_OUT]};
endmodule

// File: rtl/refclk_checker.sv
`timescale 1ns/1ps
module refclk_checker
  import refclk_pkg::*;
(
  input logic             src_clk,
  input logic             ref_clk,
  input logic             rst_n,
  input div_cfg_t         cfg_in,
  input div_cfg_t         cfg_q,
  input logic [DIV_W-1:0] cnt,
  input logic             phase,
  input logic [1:0]       en,
  input logic             clk0,
  input logic             clk1
);
  logic [DIV_W-1:0] n_chk, hi_chk;
  assign n_chk  = eff_div(cfg_q.div);
  assign hi_chk = n_chk >> 1;

  p_cnt_range_r5: assert property (@(posedge src_clk) disable iff (!rst_n)
    cnt < n_chk);

  p_phase_split_r6: assert property (@(posedge src_clk) disable iff (!rst_n)
    phase == (cnt < hi_chk));

  p_restart_r9: assert property (@(posedge src_clk) disable iff (!rst_n)
    (cfg_in != cfg_q) |=> (cnt == '0));

  p_reset_low_r8: assert property (@(negedge ref_clk)
    !rst_n |-> (!clk0 && !clk1));

  p_gate0_r7: assert property (@(negedge ref_clk) disable iff (!rst_n)
    !en[0] |-> !clk0);

  p_gate1_r7: assert property (@(negedge ref_clk) disable iff (!rst_n)
    !en[1] |-> !clk1);
endmodule

bind dual_refclk_gen refclk_checker u_chk (
  .src_clk (src_clk),
  .ref_clk (ref_clk_i),
  .rst_n   (rst_ni),
  .cfg_in  (live_cfg),
  .cfg_q   (cfg_q),
  .cnt     (div_cnt),
  .phase   (div_phase),
  .en      (out_en),
  .clk0    (ref_clk0_o),
  .clk1    (ref_clk1_o)
);

// File: tb/dual_refclk_gen_bench.sv
`timescale 1ns/1ps
module dual_refclk_gen_bench;
  logic        ref_clk = 0, io_clk = 0, cpu_clk = 0, mem_clk = 0;
  logic        rst_ni = 0;
  logic [31:0] io_ctrl = 0, cpu_ctrl = 0, mem_ctrl = 0, clk_ctrl = 0;
  logic        out0, out1;
  logic [20:0] mult;
  int          n_chk = 0, n_fail = 0;
  int          e0 = 0, e1 = 0;
  bit          done = 0;

  always #2.5 ref_clk = ~ref_clk;   // 200 MHz
  always #1.5 io_clk  = ~io_clk;    // 3 ns
  always #1.0 cpu_clk = ~cpu_clk;   // 2 ns
  always #2.0 mem_clk = ~mem_clk;   // 4 ns

  always @(posedge out0) e0++;
  always @(posedge out1) e1++;

  dual_refclk_gen u_dual_refclk_gen (
    .ref_clk_i(ref_clk), .rst_ni(rst_ni),
    .io_fast_clk_i(io_clk), .cpu_fast_clk_i(cpu_clk), .mem_fast_clk_i(mem_clk),
    .io_pll_ctrl_i(io_ctrl), .cpu_pll_ctrl_i(cpu_ctrl), .mem_pll_ctrl_i(mem_ctrl),
    .clk_ctrl_i(clk_ctrl), .ref_clk0_o(out0), .ref_clk1_o(out1), .pll_mult_o(mult)
  );

  function automatic logic [31:0] cw(input int sel, input int div, input int en);
    return (32'(div) << 8) | (32'(sel) << 4) | 32'(en);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] c);
    @(posedge ref_clk); #1;
    clk_ctrl = c;
    #100;
  endtask

  task automatic count_window(output int c0, output int c1);
    e0 = 0; e1 = 0;
    #840;
    c0 = e0; c1 = e1;
  endtask

  task automatic measure(input string req, input real exp_hi, input real exp_per);
    real t0, t1, t2;
    @(posedge out0); t0 = $realtime;
    @(negedge out0); t1 = $realtime;
    @(posedge out0); t2 = $realtime;
    check((t1 - t0 > exp_hi - 0.01) && (t1 - t0 < exp_hi + 0.01), req, "high time", t1 - t0, exp_hi);
    check((t2 - t0 > exp_per - 0.01) && (t2 - t0 < exp_per + 0.01), req, "period", t2 - t0, exp_per);
  endtask

  task automatic t_reset_r8();
    int c0, c1;
    clk_ctrl = cw(0, 2, 3);
    count_window(c0, c1);
    check(c0 == 0 && c1 == 0, "R8", "edges in reset", c0 + c1, 0);
    check(out0 == 0 && out1 == 0, "R8", "level in reset", out0 | out1, 0);
    @(posedge ref_clk); #1; rst_ni = 1;
    #60;
    measure("R8", 3.0, 6.0);
  endtask

  task automatic t_even_r6();
    apply(cw(0, 4, 1));
    measure("R6", 6.0, 12.0);
  endtask

  task automatic t_odd_r6();
    apply(cw(2, 5, 1));
    measure("R6", 4.0, 10.0);
    apply(cw(3, 3, 1));
    measure("R4", 4.0, 12.0);
  endtask

  task automatic t_sel1_r4();
    apply(cw(1, 2, 1));
    measure("R4", 3.0, 6.0);
  endtask

  task automatic t_undivided_r5();
    int c0, c1;
    apply(cw(3, 0, 1));
    count_window(c0, c1);
    check(c0 >= 209 && c0 <= 211, "R5", "div0 edges", c0, 210);
    apply(cw(3, 1, 1));
    count_window(c0, c1);
    check(c0 >= 209 && c0 <= 211, "R5", "div1 edges", c0, 210);
  endtask

  task automatic t_bypass_r1();
    io_ctrl = 32'h13;
    apply(cw(0, 2, 1));
    measure("R1", 5.0, 10.0);
    io_ctrl = 32'h0;
  endtask

  task automatic t_off_r2();
    int c0, c1;
    io_ctrl = 32'h2;
    apply(cw(0, 1, 3));
    count_window(c0, c1);
    check(c0 == 0 && c1 == 0, "R2", "power-down edges", c0 + c1, 0);
    io_ctrl = 32'h1;
    count_window(c0, c1);
    check(c0 == 0 && c1 == 0, "R2", "pll reset edges", c0 + c1, 0);
    io_ctrl = 32'h0;
  endtask

  task automatic t_normal_r3();
    int c0, c1;
    io_ctrl  = 32'h2A << 12;
    cpu_ctrl = 32'h15 << 12;
    mem_ctrl = 32'h7F << 12;
    apply(cw(0, 1, 1));
    check(mult == {7'h7F, 7'h15, 7'h2A}, "R3", "multiplier status", mult, {7'h7F, 7'h15, 7'h2A});
    count_window(c0, c1);
    check(c0 >= 279 && c0 <= 281, "R3", "fast clock edges", c0, 280);
    io_ctrl = 0; cpu_ctrl = 0; mem_ctrl = 0;
  endtask

  task automatic t_enable_r7();
    int c0, c1;
    apply(cw(0, 2, 1));
    count_window(c0, c1);
    check(c1 == 0, "R7", "out1 disabled edges", c1, 0);
    check(c0 >= 139 && c0 <= 141, "R7", "out0 enabled edges", c0, 140);
    apply(cw(0, 2, 2));
    count_window(c0, c1);
    check(c0 == 0, "R7", "out0 disabled edges", c0, 0);
    check(c1 >= 139 && c1 <= 141, "R7", "out1 enabled edges", c1, 140);
    apply(cw(0, 2, 0));
    count_window(c0, c1);
    check(c0 == 0 && c1 == 0 && out0 == 0 && out1 == 0, "R7", "both disabled", c0 + c1, 0);
  endtask

  task automatic t_restart_r9();
    real t;
    apply(cw(0, 6, 1));
    @(negedge out0); #1;
    t = $realtime;
    clk_ctrl = cw(0, 2, 1);
    @(posedge out0);
    check($realtime - t <= 3.01, "R9", "delay to restart edge", $realtime - t, 3.0);
    #60;
    measure("R9", 3.0, 6.0);
  endtask

  initial begin
    t_reset_r8();
    t_even_r6();
    t_odd_r6();
    t_sel1_r4();
    t_undivided_r5();
    t_bypass_r1();
    t_off_r2();
    t_normal_r3();
    t_enable_r7();
    t_restart_r9();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule